// File: doc/BRIEF.md
# Two-Phase Page DMA Sequencer

This block moves one 512-byte flash page between a local page buffer and host memory. The move is always done in two phases. The internal phase exchanges bytes with the flash over a byte-stream handshake. The memory phase exchanges 32-bit beats with host memory over a simple request/ready master port.

Software writes the memory base address and then arms one phase through the settings register. For a page read it arms the internal phase with the read-direction bit set. For a page write it arms the memory phase with the direction bit clear. When the armed phase finishes, the sequencer raises that phase's done status and starts the other phase itself, keeping the same direction. The end of the second phase ends the operation.

A memory error aborts the operation at once and raises an error status. Writing zero to the settings register stops all activity. Each status bit has an enable bit, and the interrupt output is the OR of the enabled status bits.

Top module: `page_dma_seq`

## Requirements
- R1: After reset, the settings, address, enable and status registers all read 0, and irq, mem_valid, fl_rx_ready and fl_tx_valid are all low.
- R2: Settings register (address 0) has three bits: bit0 selects read direction, bit1 arms the internal phase, bit2 arms the memory phase. While idle, a write with exactly one select bit set starts that phase, and the phase's handshake output is active in the next cycle. A write with both select bits set is ignored.
- R3: In a read-direction internal phase, the block accepts 512 bytes on fl_rx. It stores them little-endian: byte 4k+i goes to bits 8i+7..8i of buffer word k.
- R4: In a read-direction memory phase, the block issues 128 write beats (mem_write=1). Beat k carries buffer word k to address base+4k. A beat that is not accepted holds its address.
- R5: A write-direction operation first reads 128 beats (mem_write=0) from base+4k into buffer word k. It then emits the 512 bytes on fl_tx, byte 4k+i taken from bits 8i+7..8i of word k.
- R6: When the first phase completes, the other phase starts with the same direction. When the second phase completes, the block goes idle, and the settings select bits read back 0 while bit0 keeps the direction.
- R7: Status register (address 3): bit0 is internal done, bit1 is memory done, bit2 is error. Writing 1 to a status bit clears it. irq equals the OR of (status AND enable), where enable is address 2 with the same bit positions.
- R8: If mem_err is high on an accepted beat, the block goes idle at once and sets the error bit. No done bit is set for the aborted phase, and no further beats are issued.
- R9: Writing 0 to the settings register stops any phase at once and leaves the status unchanged.
- R10: A settings write with a select bit set, made while a phase is running, is ignored.
- R11: The capability register (address 4) reads 3, with both DMA support bits set. The address register (address 1) reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory beat accept |
| mem_write | output | 1 | 1 = beat writes memory |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Beat write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_err | input | 1 | Error flag on an accepted beat |
| fl_rx_valid | input | 1 | Flash byte available |
| fl_rx_ready | output | 1 | Block accepts flash byte |
| fl_rx_data | input | 8 | Flash byte in |
| fl_tx_valid | output | 1 | Byte available for flash |
| fl_tx_ready | input | 1 | Flash accepts byte |
| fl_tx_data | output | 8 | Byte out to flash |

## Verification
A settings write takes effect at the clock edge where it is presented, so the armed phase's handshake output is due in the cycle that follows. A completing transfer updates the status bits, the irq and the switch to the other phase at that same edge. Register reads are combinational. The bench drives all inputs and samples all outputs at the falling edge. It decides each handshake at the falling edge before the rising edge that completes it, so every expected value matches the cycle in which the design's registered state changes.

// File: rtl/page_dma_pkg.sv
package page_dma_pkg;
  localparam int PAGE_BYTES = 512;
  localparam int WORD_BYTES = 4;
  localparam int BEATS      = PAGE_BYTES / WORD_BYTES;
  localparam int CNT_W      = $clog2(PAGE_BYTES);
  localparam int IDX_W      = $clog2(BEATS);
  localparam int RA_W       = 3;

  localparam logic [RA_W-1:0] RA_SET  = 3'd0;
  localparam logic [RA_W-1:0] RA_ADDR = 3'd1;
  localparam logic [RA_W-1:0] RA_IEN  = 3'd2;
  localparam logic [RA_W-1:0] RA_STS  = 3'd3;
  localparam logic [RA_W-1:0] RA_CAP  = 3'd4;

  localparam logic [31:0] CAP_VALUE = 32'h0000_0003;

  typedef enum logic [1:0] {PH_IDLE, PH_INT, PH_MEM} phase_e;
endpackage

// File: rtl/page_dma_ctrl.sv
module page_dma_ctrl
  import page_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic [2:0]       set_bits,
  input  logic             byte_hs,
  input  logic             beat_hs,
  input  logic             beat_err,
  output phase_e           phase,
  output logic             dir_rd,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_int,
  output logic             ev_mem,
  output logic             ev_err
);
  phase_e           phase_q, phase_d;
  logic             dir_q, dir_d, second_q, second_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             arm, stop, xfer, last;

  always_comb begin
    arm  = set_we && (phase_q == PH_IDLE) && (set_bits[1] ^ set_bits[2]);
    stop = set_we && (set_bits == 3'b000);
    xfer = ((phase_q == PH_INT) && byte_hs) || ((phase_q == PH_MEM) && beat_hs);
    last = (phase_q == PH_INT) ? (cnt_q == CNT_W'(PAGE_BYTES - 1))
                               : (cnt_q == CNT_W'(BEATS - 1));
    phase_d  = phase_q;
    dir_d    = dir_q;
    second_d = second_q;
    cnt_d    = cnt_q;
    ev_int   = 1'b0;
    ev_mem   = 1'b0;
    ev_err   = 1'b0;
    if (stop) begin
      phase_d = PH_IDLE;
    end else if (arm) begin
      phase_d  = set_bits[1] ? PH_INT : PH_MEM;
      dir_d    = set_bits[0];
      second_d = 1'b0;
      cnt_d    = '0;
    end else if ((phase_q == PH_MEM) && beat_hs && beat_err) begin
      ev_err  = 1'b1;
      phase_d = PH_IDLE;
    end else if (xfer) begin
      if (last) begin
        cnt_d    = '0;
        ev_int   = (phase_q == PH_INT);
        ev_mem   = (phase_q == PH_MEM);
        second_d = 1'b1;
        if (second_q)                phase_d = PH_IDLE;
        else if (phase_q == PH_INT)  phase_d = PH_MEM;
        else                         phase_d = PH_INT;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      dir_q    <= 1'b0;
      second_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      phase_q  <= phase_d;
      dir_q    <= dir_d;
      second_q <= second_d;
      cnt_q    <= cnt_d;
    end
  end

  assign phase  = phase_q;
  assign dir_rd = dir_q;
  assign cnt    = cnt_q;
endmodule

// File: rtl/page_dma_buf.sv
module page_dma_buf
  import page_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             mem_phase,
  input  logic             rx_hs,
  input  logic [7:0]       rx_byte,
  input  logic             cap_hs,
  input  logic [31:0]      cap_word,
  output logic [31:0]      rd_word,
  output logic [7:0]       tx_byte
);
  logic [31:0]      store [BEATS];
  logic [23:0]      acc_q, acc_d;
  logic [IDX_W-1:0] byte_word, rd_idx;

  always_comb begin
    byte_word = cnt[CNT_W-1:2];
    rd_idx    = mem_phase ? cnt[IDX_W-1:0] : byte_word;
    rd_word   = store[rd_idx];
    tx_byte   = rd_word[8*cnt[1:0] +: 8];
    acc_d     = acc_q;
    if (rx_hs && (cnt[1:0] != 2'd3)) acc_d[8*cnt[1:0] +: 8] = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_ff @(posedge clk) begin
    if (rx_hs && (cnt[1:0] == 2'd3)) store[byte_word] <= {rx_byte, acc_q};
    else if (cap_hs)                 store[cnt[IDX_W-1:0]] <= cap_word;
  end
endmodule

// File: rtl/page_dma_regs.sv
module page_dma_regs
  import page_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RA_W-1:0] addr,
  input  logic [31:0]     wdata,
  input  phase_e          phase,
  input  logic            dir_rd,
  input  logic            ev_int,
  input  logic            ev_mem,
  input  logic            ev_err,
  output logic [AW-1:0]   base,
  output logic [31:0]     rdata,
  output logic            irq
);
  logic [AW-1:0] base_q, base_d;
  logic [2:0]    ien_q, ien_d, sts_q, sts_d, clr;

  always_comb begin
    base_d = base_q;
    ien_d  = ien_q;
    clr    = 3'b000;
    if (we && addr == RA_ADDR) base_d = wdata[AW-1:0];
    if (we && addr == RA_IEN)  ien_d  = wdata[2:0];
    if (we && addr == RA_STS)  clr    = wdata[2:0];
    sts_d = (sts_q & ~clr) | {ev_err, ev_mem, ev_int};
    case (addr)
      RA_SET:  rdata = {29'd0, phase == PH_MEM, phase == PH_INT, dir_rd};
      RA_ADDR: rdata = 32'(base_q);
      RA_IEN:  rdata = {29'd0, ien_q};
      RA_STS:  rdata = {29'd0, sts_q};
      RA_CAP:  rdata = CAP_VALUE;
      default: rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ien_q  <= '0;
      sts_q  <= '0;
    end else begin
      base_q <= base_d;
      ien_q  <= ien_d;
      sts_q  <= sts_d;
    end
  end

  assign base = base_q;
  assign irq  = |(sts_q & ien_q);
endmodule

// File: rtl/page_dma_seq.sv
module page_dma_seq
  import page_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_err,
  input  logic            fl_rx_valid,
  output logic            fl_rx_ready,
  input  logic [7:0]      fl_rx_data,
  output logic            fl_tx_valid,
  input  logic            fl_tx_ready,
  output logic [7:0]      fl_tx_data
);
  phase_e           phase;
  logic             dir_rd, ev_int, ev_mem, ev_err;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    base;
  logic             rx_hs, tx_hs, beat_hs, set_we;

  assign set_we      = reg_we && (reg_addr == RA_SET);
  assign fl_rx_ready = (phase == PH_INT) && dir_rd;
  assign fl_tx_valid = (phase == PH_INT) && !dir_rd;
  assign mem_valid   = (phase == PH_MEM);
  assign mem_write   = dir_rd;
  assign rx_hs       = fl_rx_valid && fl_rx_ready;
  assign tx_hs       = fl_tx_valid && fl_tx_ready;
  assign beat_hs     = mem_valid && mem_ready;
  assign mem_addr    = base + AW'({cnt[IDX_W-1:0], 2'b00});

  page_dma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .set_bits(reg_wdata[2:0]),
    .byte_hs(rx_hs || tx_hs), .beat_hs(beat_hs), .beat_err(mem_err),
    .phase(phase), .dir_rd(dir_rd), .cnt(cnt),
    .ev_int(ev_int), .ev_mem(ev_mem), .ev_err(ev_err)
  );

  page_dma_buf u_buf (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .mem_phase(mem_valid),
    .rx_hs(rx_hs), .rx_byte(fl_rx_data),
    .cap_hs(beat_hs && !dir_rd), .cap_word(mem_rdata),
    .rd_word(mem_wdata), .tx_byte(fl_tx_data)
  );

  page_dma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .phase(phase), .dir_rd(dir_rd), .ev_int(ev_int), .ev_mem(ev_mem),
    .ev_err(ev_err), .base(base), .rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: rtl/page_dma_seq_chk.sv
module page_dma_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [2:0]    set_bits,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_err,
  input logic [AW-1:0] mem_addr,
  input logic          fl_rx_ready,
  input logic          fl_tx_valid
);
  // R2
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_rx_ready, fl_tx_valid, mem_valid}));

  // R8
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_err) |=> !mem_valid);

  // R9
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && set_bits == 3'd0)
      |=> !(mem_valid || fl_rx_ready || fl_tx_valid));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !reg_we) |=> (mem_valid && $stable(mem_addr)));
endmodule

bind page_dma_seq page_dma_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .set_bits(reg_wdata[2:0]), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_err(mem_err), .mem_addr(mem_addr), .fl_rx_ready(fl_rx_ready),
  .fl_tx_valid(fl_tx_valid)
);

// File: tb/page_dma_seq_tb.sv
`timescale 1ns/1ps
module page_dma_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq, mem_valid, mem_write, fl_rx_ready, fl_tx_valid;
  logic        mem_ready = 1'b0, mem_err = 1'b0;
  logic        fl_rx_valid = 1'b0, fl_tx_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic [7:0]  fl_rx_data = 8'd0;
  logic [7:0]  fl_tx_data;

  int n_checks = 0, n_fail = 0;
  int beat_cnt = 0, rx_cnt = 0, tx_cnt = 0, err_beat = 9999, addr_bad = 0;
  logic [31:0] base = 32'd0;
  logic [7:0]  src  [512];
  logic [7:0]  sink [512];
  logic [31:0] mem_model [128];
  logic [31:0] v;

  always #2 clk = ~clk;

  page_dma_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .fl_rx_valid(fl_rx_valid), .fl_rx_ready(fl_rx_ready),
    .fl_rx_data(fl_rx_data), .fl_tx_valid(fl_tx_valid),
    .fl_tx_ready(fl_tx_ready), .fl_tx_data(fl_tx_data)
  );

  // responders: each handshake is decided here, completed at the next rising edge
  always @(negedge clk) begin
    if (mem_valid) begin
      logic [6:0] idx;
      logic rdy;
      idx = 7'((mem_addr - base) >> 2);
      rdy = ($urandom % 4) != 0;
      mem_ready = rdy;
      mem_err   = rdy && (beat_cnt == err_beat);
      mem_rdata = mem_model[idx];
      if (rdy) begin
        if (mem_addr != base + 32'(beat_cnt) * 4) addr_bad++;
        if (mem_write) mem_model[idx] = mem_wdata;
        beat_cnt++;
      end
    end else begin
      mem_ready = 1'b0;
      mem_err   = 1'b0;
    end
    if (fl_rx_ready) begin
      fl_rx_valid = ($urandom % 4) != 0;
      fl_rx_data  = src[rx_cnt % 512];
      if (fl_rx_valid) rx_cnt++;
    end else fl_rx_valid = 1'b0;
    if (fl_tx_valid) begin
      fl_tx_ready = ($urandom % 3) != 0;
      if (fl_tx_ready) begin
        sink[tx_cnt % 512] = fl_tx_data;
        tx_cnt++;
      end
    end else fl_tx_ready = 1'b0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_sts(input logic [2:0] mask);
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      reg_rd(3'd3, s);
      if ((s[2:0] & mask) != 0) break;
    end
  endtask

  function automatic logic [31:0] pack_word(input int k);
    return {src[4*k+3], src[4*k+2], src[4*k+1], src[4*k]};
  endfunction

  task automatic clear_counts();
    beat_cnt = 0; rx_cnt = 0; tx_cnt = 0; addr_bad = 0;
  endtask

  task automatic run_read(input logic [31:0] b);
    int bad;
    for (int i = 0; i < 512; i++) src[i] = 8'($urandom);
    base = b;
    clear_counts();
    reg_wr(3'd3, 32'h7);
    reg_wr(3'd1, b);
    reg_wr(3'd0, 32'h3);
    check(fl_rx_ready === 1'b1, "R2 internal phase starts", 32'(fl_rx_ready), 1);
    wait_sts(3'b010);
    reg_rd(3'd3, v); check(v == 32'h3, "R7 both done bits", v, 3);
    reg_rd(3'd0, v); check(v == 32'h1, "R6 idle after two phases, dir kept", v, 1);
    bad = 0;
    for (int k = 0; k < 128; k++) if (mem_model[k] != pack_word(k)) bad++;
    check(bad == 0, "R3 little-endian byte packing", 32'(bad), 0);
    check(beat_cnt == 128 && addr_bad == 0, "R4 128 write beats at base+4k", 32'(beat_cnt), 128);
  endtask

  task automatic run_write(input logic [31:0] b);
    int bad;
    for (int k = 0; k < 128; k++) mem_model[k] = $urandom;
    base = b;
    clear_counts();
    reg_wr(3'd3, 32'h7);
    reg_wr(3'd1, b);
    reg_wr(3'd0, 32'h4);
    check(mem_valid === 1'b1 && mem_write === 1'b0, "R2 memory phase starts", 32'(mem_valid), 1);
    wait_sts(3'b001);
    reg_rd(3'd3, v); check(v == 32'h3, "R7 both done bits", v, 3);
    reg_rd(3'd0, v); check(v == 32'h0, "R6 idle after write", v, 0);
    bad = 0;
    for (int j = 0; j < 512; j++) if (sink[j] != mem_model[j/4][8*(j%4) +: 8]) bad++;
    check(bad == 0 && tx_cnt == 512, "R5 buffer bytes emitted in order", 32'(bad), 0);
    check(beat_cnt == 128 && addr_bad == 0, "R5 128 read beats at base+4k", 32'(beat_cnt), 128);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(3'(a), v);
      check(v == 0, "R1 register reset value", v, 0);
    end
    check({irq, mem_valid, fl_rx_ready, fl_tx_valid} == 4'b0, "R1 outputs idle",
          32'({irq, mem_valid, fl_rx_ready, fl_tx_valid}), 0);
    // R11
    reg_rd(3'd4, v); check(v == 32'h3, "R11 capability bits", v, 3);
    reg_wr(3'd1, 32'hA5C3_0F10);
    reg_rd(3'd1, v); check(v == 32'hA5C3_0F10, "R11 address readback", v, 32'hA5C3_0F10);
    // R2 both selects ignored
    reg_wr(3'd0, 32'h7);
    check({mem_valid, fl_rx_ready, fl_tx_valid} == 3'b0, "R2 both selects ignored",
          32'({mem_valid, fl_rx_ready, fl_tx_valid}), 0);
    reg_wr(3'd2, 32'h7);
    // read op, with R10 busy write inside
    for (int i = 0; i < 512; i++) src[i] = 8'($urandom);
    base = 32'h1000_0000; clear_counts();
    reg_wr(3'd1, base);
    reg_wr(3'd0, 32'h3);
    reg_wr(3'd0, 32'h4);
    reg_rd(3'd0, v); check(v == 32'h3, "R10 busy settings write ignored", v, 3);
    wait_sts(3'b010);
    reg_rd(3'd3, v); check(v == 32'h3, "R7 read op status", v, 3);
    check(beat_cnt == 128 && addr_bad == 0, "R4 read op beats", 32'(beat_cnt), 128);
    // R7 W1C and irq gating
    check(irq === 1'b1, "R7 irq with enables", 32'(irq), 1);
    reg_wr(3'd3, 32'h1);
    reg_rd(3'd3, v); check(v == 32'h2, "R7 write-one clears one bit", v, 2);
    reg_wr(3'd2, 32'h1);
    check(irq === 1'b0, "R7 irq masked", 32'(irq), 0);
    reg_wr(3'd3, 32'h2);
    reg_rd(3'd3, v); check(v == 32'h0, "R7 all clear", v, 0);
    reg_wr(3'd2, 32'h7);
    // directed and random operations
    run_write(32'h2000_0400);
    run_read(32'h0000_0000);
    for (int r = 0; r < 3; r++) begin
      if ($urandom % 2) run_read({$urandom} & 32'hFFFF_FFFC);
      else              run_write({$urandom} & 32'hFFFF_FFFC);
    end
    // R8 error in the memory phase of a read
    for (int i = 0; i < 512; i++) src[i] = 8'($urandom);
    clear_counts(); err_beat = 5;
    reg_wr(3'd3, 32'h7);
    reg_wr(3'd0, 32'h3);
    wait_sts(3'b100);
    err_beat = 9999;
    repeat (20) @(negedge clk);
    reg_rd(3'd3, v); check(v == 32'h5, "R8 error set, no memory done", v, 5);
    check(beat_cnt == 6 && mem_valid === 1'b0, "R8 no beats after error", 32'(beat_cnt), 6);
    check(irq === 1'b1, "R7 irq on error", 32'(irq), 1);
    // R9 stop mid-phase
    reg_wr(3'd3, 32'h7);
    clear_counts();
    reg_wr(3'd0, 32'h3);
    repeat (10) @(negedge clk);
    reg_wr(3'd0, 32'h0);
    check({mem_valid, fl_rx_ready, fl_tx_valid} == 3'b0, "R9 stop halts phase",
          32'({mem_valid, fl_rx_ready, fl_tx_valid}), 0);
    repeat (5) @(negedge clk);
    reg_rd(3'd3, v); check(v == 32'h0, "R9 stop leaves status", v, 0);
    // R9 then R6: a fresh arm after stop completes a whole page
    run_write(32'h0000_8000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule